// File: doc/BRIEF.md
# Line-Cycle Synchronized Energy Latch

This block makes an energy reading line-synchronous. It counts zero-crossing events of the voltage channel, one per half line cycle. When a programmed number of crossings has been seen, it copies a 32-bit internal running sum of signed energy quanta into the visible energy register and restarts the internal sum. The result is that software only ever sees energy integrated over a whole number of half cycles, which removes the ripple that a free-running readout would carry.

With the line-cycle mode off, the visible register accumulates quanta directly, and a read-with-reset request clears it. With the mode on, the register only changes at the end of a window, and read-with-reset requests are ignored. A sticky window-complete flag marks each transfer. Software clears it by writing 1. Zero-crossing detection and quantum generation take place upstream.

Top module: `lce_line_cycle_latch`

## Requirements
- R1: After reset, `energy_o` is 0 and `win_done_o` is 0.
- R2: With `lc_en_i` low, every clock edge adds the net quantum to `energy_o`. The net quantum is +1 when only `q_up_i` is high, -1 when only `q_dn_i` is high, and 0 when both or neither are high.
- R3: With `lc_en_i` low, `rd_rst_i` high loads `energy_o` with the net quantum of that same cycle, so the register is 0 when no quantum arrives.
- R4: With `lc_en_i` high, `energy_o` changes only on a transfer, and `rd_rst_i` has no effect.
- R5: With `lc_en_i` high and `half_cyc_i` = N > 0, a transfer happens on the clock edge that samples the N-th `zc_i` pulse of the window. At that edge, `energy_o` takes the net sum of all quanta sampled since the previous transfer, or since the mode was enabled, excluding the transfer cycle.
- R6: A quantum sampled in the same cycle as a transfer is counted in the next window.
- R7: `win_done_o` is set by each transfer and cleared by `clr_done_i` high. If a transfer and a clear occur in the same cycle, the flag stays set.
- R8: With `half_cyc_i` = 0, no transfer occurs. `energy_o` holds its value, and `win_done_o` is never set.
- R9: The crossing count restarts on the transfer edge. The crossing sampled at that edge closes the current window, and the next window needs N further crossings.
- R10: All energy sums wrap modulo 2^32 in two's complement. For example, one down quantum applied to 0 gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_en_i | input | 1 | Line-cycle accumulation mode enable |
| half_cyc_i | input | 16 | Half line cycles per window (0 disables transfers) |
| zc_i | input | 1 | Single-cycle zero-crossing pulse |
| q_up_i | input | 1 | Positive energy quantum |
| q_dn_i | input | 1 | Negative energy quantum |
| rd_rst_i | input | 1 | Read-with-reset request (ignored in line-cycle mode) |
| clr_done_i | input | 1 | Write-1-to-clear of the window-complete flag |
| energy_o | output | 32 | Visible energy register |
| win_done_o | output | 1 | Sticky window-complete flag |

## Verification
The assertions assume that `zc_i` arrives as a clean pulse that is sampled once per crossing. They also assume that `half_cyc_i` and `lc_en_i` are quasi-static, meaning they change only between windows and never while a property's antecedent depends on them. The stimulus follows these assumptions. It changes the mode and the window length only at phase boundaries, between idle cycles. Within each phase it randomizes only the crossing pulses, the quanta, the read-with-reset requests and the flag clears, drawing them with fixed-seed `$urandom`.

// File: rtl/lce_pkg.sv
package lce_pkg;
  localparam int unsigned ENERGY_W = 32;
  localparam int unsigned CNT_W    = 16;

  typedef logic signed [1:0] quantum_t;

  function automatic quantum_t net_quantum(input logic up, input logic dn);
    quantum_t q;
    unique case ({up, dn})
      2'b10:   q = 2'sd1;
      2'b01:   q = -2'sd1;
      default: q = 2'sd0;
    endcase
    return q;
  endfunction
endpackage

// File: rtl/lce_win_counter.sv
module lce_win_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lc_en,
  input  logic [CNT_W-1:0] half_cyc,
  input  logic             zc,
  output logic             xfer
);
  localparam int unsigned CMP_W = CNT_W + 1;

  logic [CNT_W-1:0] seen_q, seen_d;
  logic             seen_en;
  logic             count_live;
  logic [CMP_W-1:0] seen_inc;

  assign count_live = lc_en && (half_cyc != '0);
  assign seen_inc   = {1'b0, seen_q} + CMP_W'(1);
  assign xfer       = count_live && zc && (seen_inc >= {1'b0, half_cyc});

  always_comb begin
    seen_en = 1'b0;
    seen_d  = seen_q;
    if (!count_live) begin
      seen_en = (seen_q != '0);
      seen_d  = '0;
    end else if (zc) begin
      seen_en = 1'b1;
      seen_d  = xfer ? '0 : seen_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (seen_en) begin
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/lce_accum.sv
module lce_accum
  import lce_pkg::*;
#(
  parameter int unsigned ENERGY_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lc_en,
  input  logic                xfer,
  input  quantum_t            delta,
  output logic [ENERGY_W-1:0] acc
);
  logic [ENERGY_W-1:0] acc_q, acc_d;
  logic [ENERGY_W-1:0] delta_ext;
  logic                acc_en;

  assign delta_ext = ENERGY_W'(signed'(delta));

  always_comb begin
    acc_en = 1'b1;
    acc_d  = acc_q;
    if (!lc_en) begin
      acc_en = (acc_q != '0);
      acc_d  = '0;
    end else if (xfer) begin
      acc_d  = delta_ext;
    end else begin
      acc_en = (delta != 2'sd0);
      acc_d  = acc_q + delta_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/lce_snap_reg.sv
module lce_snap_reg
  import lce_pkg::*;
#(
  parameter int unsigned ENERGY_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lc_en,
  input  logic                xfer,
  input  logic                rd_rst,
  input  logic                clr_done,
  input  quantum_t            delta,
  input  logic [ENERGY_W-1:0] acc,
  output logic [ENERGY_W-1:0] energy,
  output logic                done
);
  logic [ENERGY_W-1:0] vis_q, vis_d, delta_ext;
  logic                vis_en;
  logic                done_q, done_d;

  assign delta_ext = ENERGY_W'(signed'(delta));

  always_comb begin
    vis_en = 1'b0;
    vis_d  = vis_q;
    if (lc_en) begin
      vis_en = xfer;
      vis_d  = acc;
    end else if (rd_rst) begin
      vis_en = 1'b1;
      vis_d  = delta_ext;
    end else begin
      vis_en = (delta != 2'sd0);
      vis_d  = vis_q + delta_ext;
    end
  end

  always_comb begin
    done_d = xfer | (done_q & ~clr_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q <= '0;
    end else if (vis_en) begin
      vis_q <= vis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign energy = vis_q;
  assign done   = done_q;
endmodule

// File: rtl/lce_line_cycle_latch.sv
module lce_line_cycle_latch
  import lce_pkg::*;
#(
  parameter int unsigned ENERGY_W = lce_pkg::ENERGY_W,
  parameter int unsigned CNT_W    = lce_pkg::CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lc_en_i,
  input  logic [CNT_W-1:0]    half_cyc_i,
  input  logic                zc_i,
  input  logic                q_up_i,
  input  logic                q_dn_i,
  input  logic                rd_rst_i,
  input  logic                clr_done_i,
  output logic [ENERGY_W-1:0] energy_o,
  output logic                win_done_o
);
  quantum_t            delta;
  logic                xfer;
  logic [ENERGY_W-1:0] acc;

  assign delta = net_quantum(q_up_i, q_dn_i);

  lce_win_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .lc_en    (lc_en_i),
    .half_cyc (half_cyc_i),
    .zc       (zc_i),
    .xfer     (xfer)
  );

  lce_accum #(.ENERGY_W(ENERGY_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .lc_en (lc_en_i),
    .xfer  (xfer),
    .delta (delta),
    .acc   (acc)
  );

  lce_snap_reg #(.ENERGY_W(ENERGY_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .lc_en    (lc_en_i),
    .xfer     (xfer),
    .rd_rst   (rd_rst_i),
    .clr_done (clr_done_i),
    .delta    (delta),
    .acc      (acc),
    .energy   (energy_o),
    .done     (win_done_o)
  );
endmodule

// File: rtl/lce_chk.sv
module lce_chk #(
  parameter int unsigned ENERGY_W = 32,
  parameter int unsigned CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lc_en_i,
  input logic [CNT_W-1:0]    half_cyc_i,
  input logic                zc_i,
  input logic                q_up_i,
  input logic                q_dn_i,
  input logic                rd_rst_i,
  input logic                clr_done_i,
  input logic                xfer,
  input logic [ENERGY_W-1:0] acc,
  input logic [ENERGY_W-1:0] energy_o,
  input logic                win_done_o
);
  // R2
  mode_off_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lc_en_i && !rd_rst_i && q_up_i && !q_dn_i) |=> energy_o == $past(energy_o) + ENERGY_W'(1));

  // R3
  rd_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lc_en_i && rd_rst_i && (q_up_i == q_dn_i)) |=> energy_o == '0);

  // R4
  hold_between_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_en_i && !zc_i) |=> $stable(energy_o));

  // R6
  xfer_quantum_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && q_up_i && !q_dn_i) |=> acc == ENERGY_W'(1));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> win_done_o);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done_i && !xfer) |=> !win_done_o);

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_en_i && half_cyc_i == '0) |-> !xfer);

  // R5
  xfer_needs_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> (zc_i && lc_en_i));
endmodule

bind lce_line_cycle_latch lce_chk #(.ENERGY_W(ENERGY_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lc_en_i    (lc_en_i),
  .half_cyc_i (half_cyc_i),
  .zc_i       (zc_i),
  .q_up_i     (q_up_i),
  .q_dn_i     (q_dn_i),
  .rd_rst_i   (rd_rst_i),
  .clr_done_i (clr_done_i),
  .xfer       (xfer),
  .acc        (acc),
  .energy_o   (energy_o),
  .win_done_o (win_done_o)
);

// File: tb/tb_lce_line_cycle_latch.sv
module tb_lce_line_cycle_latch;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lc_en = 1'b0;
  logic [CW-1:0] half_cyc = '0;
  logic          zc = 1'b0, up = 1'b0, dn = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [EW-1:0] energy;
  logic          done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [EW-1:0] m_vis = '0, m_acc = '0;
  int unsigned   m_seen = 0;
  logic          m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lce_line_cycle_latch dut (
    .clk(clk), .rst_n(rst_n), .lc_en_i(lc_en), .half_cyc_i(half_cyc),
    .zc_i(zc), .q_up_i(up), .q_dn_i(dn), .rd_rst_i(rd), .clr_done_i(clr),
    .energy_o(energy), .win_done_o(done)
  );

  function automatic logic [EW-1:0] qv(input logic u, input logic d);
    if (u && !d) return EW'(1);
    if (d && !u) return {EW{1'b1}};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [EW-1:0] d;
    logic          x;
    d = qv(up, dn);
    x = lc_en && (half_cyc != 0) && zc && (m_seen + 1 >= half_cyc);
    if (lc_en) begin
      if (x) m_vis = m_acc;
    end else if (rd) m_vis = d;
    else m_vis = m_vis + d;
    if (!lc_en) m_acc = '0;
    else if (x) m_acc = d;
    else m_acc = m_acc + d;
    if (!lc_en || half_cyc == 0) m_seen = 0;
    else if (zc) m_seen = x ? 0 : m_seen + 1;
    m_flag = x | (m_flag & ~clr);
  endtask

  task automatic step(input string tag, input logic z, input logic u, input logic d,
                      input logic r, input logic c);
    @(negedge clk);
    zc = z; up = u; dn = d; rd = r; clr = c;
    @(posedge clk);
    model_step();
    #(CLK_PERIOD/4);
    check({tag, " energy"}, energy, m_vis);
    check({tag, " flag"}, EW'(done), EW'(m_flag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("idle", 0, 0, 0, 0, 0);
  endtask

  task automatic rnd_phase(input string tag, input int n, input int zc_pct);
    for (int i = 0; i < n; i++)
      step(tag, ($urandom % 100) < zc_pct, $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 8) == 0, ($urandom % 6) == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #(CLK_PERIOD * 3);
    #1;
    check("R1 reset energy", energy, '0);
    check("R1 reset flag", EW'(done), '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2 / R3: mode off, direct accumulation and read-with-reset
    for (int i = 0; i < 5; i++) step("R2", 0, 1, 0, 0, 0);
    step("R2 both", 0, 1, 1, 0, 0);
    step("R3 rdrst", 0, 0, 0, 1, 0);
    check("R3 cleared", energy, '0);
    step("R3 rdrst+up", 0, 1, 0, 1, 0);
    check("R3 new value", energy, EW'(1));
    rnd_phase("R2R3", 400, 10);

    // R10: wrap below zero
    step("R10 clr", 0, 0, 0, 1, 0);
    step("R10 down", 0, 0, 1, 0, 0);
    check("R10 wrap", energy, 32'hFFFF_FFFF);

    // R5/R9: N=3 directed
    idle(1);
    @(negedge clk); half_cyc = 16'd3; lc_en = 1'b1;
    step("R4 enter", 0, 1, 0, 1, 0);
    step("R9 zc1", 1, 1, 0, 0, 0);
    step("R9 zc2", 1, 0, 0, 1, 0);
    check("R4 rdrst ignored", energy, 32'hFFFF_FFFF);
    step("R9 zc3", 1, 0, 0, 0, 0);
    check("R5 xfer value", energy, EW'(2));
    check("R7 flag set", EW'(done), EW'(1));
    step("R7 clear", 0, 0, 0, 0, 1);
    check("R7 cleared", EW'(done), '0);
    rnd_phase("R5R9 N3", 2000, 20);

    // R6: N=1, quantum in transfer cycle
    idle(1);
    @(negedge clk); half_cyc = 16'd1;
    step("R6 zc", 1, 0, 0, 0, 0);
    step("R6 up", 0, 1, 0, 0, 0);
    step("R6 up", 0, 1, 0, 0, 0);
    step("R6 zc+up", 1, 1, 0, 0, 1);
    check("R6 window sum", energy, EW'(2));
    check("R7 set beats clear", EW'(done), EW'(1));
    step("R6 zc", 1, 0, 0, 0, 0);
    check("R6 carried quantum", energy, EW'(1));
    rnd_phase("R5 N1", 1500, 30);

    // R8: N=0
    idle(1);
    @(negedge clk); half_cyc = 16'd0;
    step("R8 clr", 0, 0, 0, 0, 1);
    rnd_phase("R8 N0", 800, 50);
    check("R8 no flag", EW'(done), '0);

    // longer windows and mode toggling
    for (int k = 0; k < 6; k++) begin
      idle(1);
      @(negedge clk); half_cyc = CW'(2 + $urandom % 9); lc_en = k[0];
      rnd_phase("R5 mix", 3000, 15);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule